// File: doc/BRIEF.md
# Two-Bank Device Interrupt Controller

This block collects up to 64 device interrupt requests, organised as two banks of 32 sources, and combines them into a single interrupt line toward the host. Source n of bank b is global source 32*b+n. Each source has its own trigger mode. A level source shows pending while its request is high. An edge source latches a rising request and holds it until the device pulses its acknowledge line. The trigger mode is fixed by a configuration input at reset.

Software cannot write enables directly. An enable bit is raised by writing a 1 to a set register and dropped by writing a 1 to a clear register. A separate read-only register shows the resulting enable state. The pending register is a read-only status view. A software register per bank drives the top source of that bank, so software can raise an interrupt on its own. Access is through a plain 32-bit register bus with address, write strobe, write data and combinational read data.

Top module: `dev_irq_ctrl`

## Requirements
- R1: During reset all enables, pending bits and software bits clear and irq_o is low. The trigger-mode register of each bank loads from its 32-bit slice of mode_cfg_i (bank b uses bits 32*b+31..32*b) while rst_ni is low, and it keeps that value afterwards.
- R2: Registers are word addressed, with bank b at base + 4*b for b in {0,1}. The bases are: pending 0x100, trigger mode 0x120, enable status 0x140, enable set 0x160, enable clear 0x180, software 0x1A0. An access to one bank leaves the other bank unchanged.
- R3: A write to the set register of a bank sets each enable bit whose data bit is 1 and leaves the bits written as 0 unchanged. The enable state is visible in the status register on the cycle after the write edge.
- R4: A write to the clear register of a bank clears each enable bit whose data bit is 1 and leaves the bits written as 0 unchanged.
- R5: A source whose mode bit is 0 (level) has a pending bit equal to its request as sampled at the previous clock edge.
- R6: A source whose mode bit is 1 (edge) sets its pending bit at the edge where its request is first seen high after being low. It holds the bit after the request falls and clears it at the edge where its ack_i bit is high. A rise and an acknowledge at the same edge leave the bit set. ack_i has no effect on level sources.
- R7: irq_o is high exactly when some source in either bank is both pending and enabled. It therefore rises one edge after a request for an enabled level source rises.
- R8: Writes to the pending, trigger-mode and enable-status registers change no state.
- R9: Bit 31 of the software register is readable and writable, and its other bits read 0. That bit is ORed into the request of source 31 of the same bank, and it follows that source's trigger mode.
- R10: Reads return 0 for the set and clear registers, for misaligned addresses, and for any address outside the map.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset (trigger mode loads synchronously while low) |
| mode_cfg_i | input | 64 | Trigger mode per source, 1 = edge |
| req_i | input | 64 | Synchronous interrupt requests |
| ack_i | input | 64 | Acknowledge pulses for edge-mode sources |
| addr_i | input | 12 | Register byte address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Host interrupt |

## Verification
A register write takes effect at the clock edge where we_i is sampled, so the bench reads the register back on a later cycle. Read data is combinational, so the bench samples it 1 ns after setting the address at a falling edge. A request or acknowledge driven after a falling edge shows in the pending bits and in irq_o after the next rising edge. irq_o is also checked before that edge, to confirm that it is still low. A software write needs two edges before it shows as pending: one to store the bit and one to register it as a request. The bench waits for both edges before it reads.

// File: rtl/dic_pkg.sv
package dic_pkg;
  typedef enum logic [2:0] {
    GRP_PEND,
    GRP_MODE,
    GRP_EN,
    GRP_SET,
    GRP_CLR,
    GRP_SW,
    GRP_NONE
  } grp_e;

  // address bits above this select the register group (32-byte stride)
  localparam int unsigned GRP_LSB   = 5;
  localparam int unsigned GRP_FIRST = 8;  // 0x100 >> GRP_LSB
endpackage

// File: rtl/dic_regif.sv
module dic_regif import dic_pkg::*; #(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned REG_W     = 32,
  localparam int unsigned SRC_W    = NUM_BANKS * REG_W,
  localparam int unsigned GRP_W    = ADDR_W - GRP_LSB
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 we_i,
  input  logic [SRC_W-1:0]     pend_i,
  input  logic [SRC_W-1:0]     mode_i,
  input  logic [SRC_W-1:0]     en_i,
  input  logic [SRC_W-1:0]     sw_i,
  output logic [NUM_BANKS-1:0] set_stb_o,
  output logic [NUM_BANKS-1:0] clr_stb_o,
  output logic [NUM_BANKS-1:0] sw_stb_o,
  output logic [REG_W-1:0]     rdata_o
);
  grp_e                 grp;
  logic [NUM_BANKS-1:0] sel;

  always_comb begin
    grp = GRP_NONE;
    if (addr_i[1:0] == 2'b00 && int'(addr_i[4:2]) < NUM_BANKS) begin
      case (addr_i[ADDR_W-1:GRP_LSB])
        GRP_W'(GRP_FIRST + 0): grp = GRP_PEND;
        GRP_W'(GRP_FIRST + 1): grp = GRP_MODE;
        GRP_W'(GRP_FIRST + 2): grp = GRP_EN;
        GRP_W'(GRP_FIRST + 3): grp = GRP_SET;
        GRP_W'(GRP_FIRST + 4): grp = GRP_CLR;
        GRP_W'(GRP_FIRST + 5): grp = GRP_SW;
        default:               grp = GRP_NONE;
      endcase
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_sel
    assign sel[b]       = (grp != GRP_NONE) && (int'(addr_i[4:2]) == b);
    assign set_stb_o[b] = we_i && sel[b] && (grp == GRP_SET);
    assign clr_stb_o[b] = we_i && sel[b] && (grp == GRP_CLR);
    assign sw_stb_o[b]  = we_i && sel[b] && (grp == GRP_SW);
  end

  // set/clear are write-only and read as zero
  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (sel[b]) begin
        case (grp)
          GRP_PEND: rdata_o = pend_i[b*REG_W +: REG_W];
          GRP_MODE: rdata_o = mode_i[b*REG_W +: REG_W];
          GRP_EN:   rdata_o = en_i[b*REG_W +: REG_W];
          GRP_SW:   rdata_o = sw_i[b*REG_W +: REG_W];
          default:  rdata_o = '0;
        endcase
      end
    end
  end

  // R2: one write access reaches at most one bank register
  a_r2_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({set_stb_o, clr_stb_o, sw_stb_o}));

  // R8: no strobe without a write
  a_r8_no_stb_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |-> ({set_stb_o, clr_stb_o, sw_stb_o} == '0));
endmodule

// File: rtl/dic_bank.sv
module dic_bank #(
  parameter int unsigned W      = 32,
  parameter int unsigned SW_BIT = W - 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] mode_cfg_i,
  input  logic [W-1:0] req_i,
  input  logic [W-1:0] ack_i,
  input  logic [W-1:0] wdata_i,
  input  logic         set_stb_i,
  input  logic         clr_stb_i,
  input  logic         sw_stb_i,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] mode_o,
  output logic [W-1:0] en_o,
  output logic [W-1:0] sw_o,
  output logic         hit_o
);
  logic [W-1:0] mode_q, en_q, pend_q, req_q, req_eff, pend_d;
  logic         sw_q;

  // trigger mode captured while reset is held
  always_ff @(posedge clk_i) begin
    if (!rst_ni) mode_q <= mode_cfg_i;
  end

  always_comb begin
    req_eff         = req_i;
    req_eff[SW_BIT] = req_i[SW_BIT] | sw_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
    end else if (clr_stb_i) begin
      en_q <= en_q & ~wdata_i;
    end else if (set_stb_i) begin
      en_q <= en_q | wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sw_q <= 1'b0;
    else if (sw_stb_i) sw_q <= wdata_i[SW_BIT];
  end

  // edge: rise sets, ack clears, rise wins; level: follow request
  assign pend_d = (mode_q & ((req_eff & ~req_q) | (pend_q & ~ack_i)))
                | (~mode_q & req_eff);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= '0;
      pend_q <= '0;
    end else begin
      req_q  <= req_eff;
      pend_q <= pend_d;
    end
  end

  always_comb begin
    sw_o         = '0;
    sw_o[SW_BIT] = sw_q;
  end

  assign pend_o = pend_q;
  assign mode_o = mode_q;
  assign en_o   = en_q;
  assign hit_o  = |(pend_q & en_q);

  a_r1_mode_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> $stable(mode_q));

  a_r3_set_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_stb_i && !clr_stb_i) |=> ((en_q & $past(wdata_i)) == $past(wdata_i)));

  a_r4_clr_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_stb_i |=> ((en_q & $past(wdata_i)) == '0));

  a_r3_zero_bits_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_stb_i || clr_stb_i) |=> (((en_q ^ $past(en_q)) & ~$past(wdata_i)) == '0));

  a_r8_en_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(set_stb_i || clr_stb_i) |=> $stable(en_q));

  a_r5_level_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> (((pend_q ^ $past(req_eff)) & ~mode_q) == '0));

  a_r6_edge_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> (($past(pend_q & mode_q & ~ack_i) & ~pend_q) == '0));
endmodule

// File: rtl/dev_irq_ctrl.sv
module dev_irq_ctrl #(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned REG_W     = 32,
  parameter int unsigned ADDR_W    = 12,
  localparam int unsigned SRC_W    = NUM_BANKS * REG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SRC_W-1:0]  mode_cfg_i,
  input  logic [SRC_W-1:0]  req_i,
  input  logic [SRC_W-1:0]  ack_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              irq_o
);
  logic [SRC_W-1:0]     pend, mode, en, sw;
  logic [NUM_BANKS-1:0] set_stb, clr_stb, sw_stb, hit;

  dic_regif #(
    .NUM_BANKS(NUM_BANKS),
    .ADDR_W   (ADDR_W),
    .REG_W    (REG_W)
  ) i_regif (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .we_i     (we_i),
    .pend_i   (pend),
    .mode_i   (mode),
    .en_i     (en),
    .sw_i     (sw),
    .set_stb_o(set_stb),
    .clr_stb_o(clr_stb),
    .sw_stb_o (sw_stb),
    .rdata_o  (rdata_o)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    dic_bank #(.W(REG_W)) i_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .mode_cfg_i(mode_cfg_i[b*REG_W +: REG_W]),
      .req_i     (req_i[b*REG_W +: REG_W]),
      .ack_i     (ack_i[b*REG_W +: REG_W]),
      .wdata_i   (wdata_i),
      .set_stb_i (set_stb[b]),
      .clr_stb_i (clr_stb[b]),
      .sw_stb_i  (sw_stb[b]),
      .pend_o    (pend[b*REG_W +: REG_W]),
      .mode_o    (mode[b*REG_W +: REG_W]),
      .en_o      (en[b*REG_W +: REG_W]),
      .sw_o      (sw[b*REG_W +: REG_W]),
      .hit_o     (hit[b])
    );
  end

  assign irq_o = |hit;

  a_r7_irq_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (en != '0));

  a_r7_irq_needs_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (pend != '0));
endmodule

// File: tb/test_dev_irq_ctrl.sv
`timescale 1ns/1ps
module test_dev_irq_ctrl;
  localparam logic [63:0] MODE_CFG = {32'h8000_0000, 32'h0000_FF00};

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] req_i = '0;
  logic [63:0] ack_i = '0;
  logic [11:0] addr_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk_i = ~clk_i;

  dev_irq_ctrl i_dev_irq_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_cfg_i(MODE_CFG),
    .req_i     (req_i),
    .ack_i     (ack_i),
    .addr_i    (addr_i),
    .we_i      (we_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .irq_o     (irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; we_i = 1'b1; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk_i);
    addr_i = a;
    #1;
    chk(tag, rdata_o, exp);
  endtask

  task automatic t_reset();
    rd_chk(12'h100, 32'h0, "R1 pend0");
    rd_chk(12'h104, 32'h0, "R1 pend1");
    rd_chk(12'h140, 32'h0, "R1 en0");
    rd_chk(12'h144, 32'h0, "R1 en1");
    rd_chk(12'h1A0, 32'h0, "R1 sw0");
    rd_chk(12'h120, MODE_CFG[31:0], "R1 R2 mode0");
    rd_chk(12'h124, MODE_CFG[63:32], "R1 R2 mode1");
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_enable();
    bus_wr(12'h160, 32'h0000_00F0);
    rd_chk(12'h140, 32'h0000_00F0, "R3 set");
    bus_wr(12'h160, 32'h0000_000F);
    rd_chk(12'h140, 32'h0000_00FF, "R3 set keeps");
    bus_wr(12'h160, 32'h0);
    rd_chk(12'h140, 32'h0000_00FF, "R3 zero write");
    bus_wr(12'h180, 32'h0000_0030);
    rd_chk(12'h140, 32'h0000_00CF, "R4 clear");
    bus_wr(12'h180, 32'h0);
    rd_chk(12'h140, 32'h0000_00CF, "R4 zero write");
    bus_wr(12'h164, 32'h0000_0001);
    rd_chk(12'h144, 32'h0000_0001, "R2 bank1 set");
    rd_chk(12'h140, 32'h0000_00CF, "R2 bank0 untouched");
    rd_chk(12'h160, 32'h0, "R10 set reads zero");
    rd_chk(12'h184, 32'h0, "R10 clear reads zero");
    rd_chk(12'h108, 32'h0, "R10 slot 2");
    rd_chk(12'h1C0, 32'h0, "R10 past map");
    rd_chk(12'h000, 32'h0, "R10 low addr");
    rd_chk(12'h101, 32'h0, "R10 misaligned");
    chk("R7 idle irq", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_level();
    req_i[3] = 1'b1;
    chk("R7 irq before edge", {31'b0, irq_o}, 32'h0);
    tick();
    #1;
    chk("R7 irq after edge", {31'b0, irq_o}, 32'h1);
    rd_chk(12'h100, 32'h0000_0008, "R5 level pending");
    ack_i[3] = 1'b1;
    tick();
    ack_i[3] = 1'b0;
    rd_chk(12'h100, 32'h0000_0008, "R6 ack ignored on level");
    req_i[3] = 1'b0;
    tick();
    rd_chk(12'h100, 32'h0, "R5 level drop");
    chk("R7 irq drop", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_edge();
    bus_wr(12'h160, 32'h0000_0200);
    req_i[9] = 1'b1;
    tick();
    req_i[9] = 1'b0;
    rd_chk(12'h100, 32'h0000_0200, "R6 edge latch");
    chk("R7 edge irq", {31'b0, irq_o}, 32'h1);
    repeat (3) tick();
    rd_chk(12'h100, 32'h0000_0200, "R6 edge hold");
    ack_i[9] = 1'b1;
    tick();
    ack_i[9] = 1'b0;
    rd_chk(12'h100, 32'h0, "R6 ack clears");
    chk("R7 irq after ack", {31'b0, irq_o}, 32'h0);
    req_i[9] = 1'b1; ack_i[9] = 1'b1;
    tick();
    ack_i[9] = 1'b0;
    rd_chk(12'h100, 32'h0000_0200, "R6 rise beats ack");
    ack_i[9] = 1'b1;
    tick();
    ack_i[9] = 1'b0;
    rd_chk(12'h100, 32'h0, "R6 ack with req high");
    tick();
    rd_chk(12'h100, 32'h0, "R6 no retrigger");
    req_i[9] = 1'b0;
    tick();
  endtask

  task automatic t_mask();
    req_i[20] = 1'b1;
    tick();
    rd_chk(12'h100, 32'h0010_0000, "R5 masked pending");
    chk("R7 masked irq", {31'b0, irq_o}, 32'h0);
    req_i[32] = 1'b1;
    tick();
    rd_chk(12'h104, 32'h0000_0001, "R5 bank1 pending");
    chk("R7 bank1 irq", {31'b0, irq_o}, 32'h1);
    req_i[32] = 1'b0; req_i[20] = 1'b0;
    tick();
    #1;
    chk("R7 irq released", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_readonly();
    req_i[5] = 1'b1;
    tick();
    rd_chk(12'h100, 32'h0000_0020, "R8 pend before");
    bus_wr(12'h100, 32'hFFFF_FFFF);
    rd_chk(12'h100, 32'h0000_0020, "R8 pend write");
    bus_wr(12'h120, 32'h0);
    rd_chk(12'h120, MODE_CFG[31:0], "R8 mode write");
    bus_wr(12'h124, 32'h0);
    rd_chk(12'h124, MODE_CFG[63:32], "R8 mode1 write");
    bus_wr(12'h140, 32'hFFFF_FFFF);
    rd_chk(12'h140, 32'h0000_02CF, "R8 en write");
    chk("R8 irq unchanged", {31'b0, irq_o}, 32'h0);
    req_i[5] = 1'b0;
    tick();
  endtask

  task automatic t_sw();
    bus_wr(12'h160, 32'h8000_0000);
    bus_wr(12'h1A0, 32'hFFFF_FFFF);
    rd_chk(12'h1A0, 32'h8000_0000, "R9 sw readback");
    tick();
    rd_chk(12'h100, 32'h8000_0000, "R9 sw pending");
    chk("R9 sw irq", {31'b0, irq_o}, 32'h1);
    bus_wr(12'h1A0, 32'h0);
    tick();
    rd_chk(12'h1A0, 32'h0, "R9 sw cleared");
    rd_chk(12'h100, 32'h0, "R9 level sw drop");
    chk("R9 irq drop", {31'b0, irq_o}, 32'h0);
    bus_wr(12'h164, 32'h8000_0000);
    bus_wr(12'h1A4, 32'h8000_0000);
    tick();
    rd_chk(12'h104, 32'h8000_0000, "R9 bank1 sw edge");
    bus_wr(12'h1A4, 32'h0);
    tick();
    rd_chk(12'h104, 32'h8000_0000, "R9 edge sw held");
    chk("R9 edge irq", {31'b0, irq_o}, 32'h1);
    ack_i[63] = 1'b1;
    tick();
    ack_i[63] = 1'b0;
    rd_chk(12'h104, 32'h0, "R9 edge sw ack");
    chk("R9 irq after ack", {31'b0, irq_o}, 32'h0);
    rd_chk(12'h1A0, 32'h0, "R2 bank0 sw untouched");
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    tick();
    t_reset();
    t_enable();
    t_level();
    t_edge();
    t_mask();
    t_readonly();
    t_sw();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule